// File: doc/BRIEF.md
# Iterative Integer Multiply-Accumulate Unit

This block computes one 64-bit integer result from two multiplicand operands, an addend and an operation code. It covers several operation families. Full-width multiply-add and multiply-subtract keep the low half of the product. Widening 32x32 multiply-add and multiply-subtract come in signed and unsigned forms. The high-half multiplies return the upper 64 bits of the 128-bit product, again in signed and unsigned forms. A plain multiply is the add form with a zero addend. A negated multiply is the subtract form with a zero addend. The unit produces no flags and gives no overflow indication.

One shift-and-add engine does the work for every operation. Signed operations multiply the operand magnitudes and negate the 128-bit product at the end when the two signs differ. The engine consumes one multiplier bit per cycle and stops as soon as no set bits remain in the multiplier magnitude, so small multipliers finish early. Control is a plain start/busy/done handshake. The operands, the code and the mode bit are captured on the edge where `start` is high and the unit is idle. The unit has no back-pressure: the result is held in its register until the next operation finishes, and a caller that needs it must read it in the `done` cycle or at any time before the next completion.

Top module: `imac_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy`, `done` and `result` are all 0.
- R2: Any code other than 1 through 7 is a full-width multiply-add. This includes code 0 and codes 8 to 15. `result` is `(addend + opa*opb) mod 2^64`, and it is the same whether the operands are read as signed or unsigned.
- R3: Code 1 is full-width multiply-subtract. `result` is `(addend - opa*opb) mod 2^64`. With a zero addend this gives the negated product.
- R4: Codes 2 (add) and 4 (subtract) are the signed widening forms. Bits 31:0 of each operand are sign-extended to 64 bits and multiplied. The 64-bit product is added to or subtracted from the full 64-bit addend. Bits 63:32 of the operands are ignored.
- R5: Codes 3 (add) and 5 (subtract) are the unsigned widening forms. They work like R4, but bits 31:0 of each operand are zero-extended.
- R6: Code 6 returns bits 127:64 of the two's-complement product of the 64-bit operands. The addend is ignored.
- R7: Code 7 returns bits 127:64 of the unsigned product of the 64-bit operands. The addend is ignored.
- R8: When `mode32` is high, codes 0, 1 and 8 to 15 work on bits 31:0 of both operands and the addend. They return the 32-bit result zero-extended to 64 bits. Codes 2 to 7 ignore `mode32`.
- R9: `done` rises exactly n cycles after the accepting edge and lasts one cycle. Here n is the bit length of the multiplier magnitude, with a minimum of 1. The multiplier magnitude is the absolute value of `opb` as the code interprets it (sign-extended, zero-extended or 32-bit-masked, as above).
- R10: `busy` is high from the cycle after an accepting edge up to, but not including, the `done` cycle. `busy` and `done` are never high together. A `start` pulse raised while `busy` is high is ignored.
- R11: `result` changes only in a `done` cycle and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation; taken only when idle |
| op | input | 4 | Operation code |
| mode32 | input | 1 | 32-bit mode for the full-width forms |
| opa | input | 64 | Multiplicand |
| opb | input | 64 | Multiplier; its magnitude sets the latency |
| addend | input | 64 | Accumulator input |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is updated |
| result | output | 64 | Registered result |

## Verification
Each result is due exactly n clock edges after the accepting edge, with n fixed by R9. No result is due during reset. The bench keeps a behavioural reference that works out n from the multiplier magnitude when it accepts a request and then counts it down. The expected `busy`, `done` and `result` therefore change in the same cycles as the design's. All three outputs are compared at every falling edge, half a cycle after the edge that updates them. Multipliers of 0, 1, -1 and a lone top bit exercise the shortest and longest latencies. A request issued in mid-operation confirms that nothing moves before the pending `done`.

// File: rtl/imac_pkg.sv
package imac_pkg;

  typedef enum logic [3:0] {
    OP_MAC   = 4'd0,
    OP_MSB   = 4'd1,
    OP_SWMAC = 4'd2,
    OP_UWMAC = 4'd3,
    OP_SWMSB = 4'd4,
    OP_UWMSB = 4'd5,
    OP_SHI   = 4'd6,
    OP_UHI   = 4'd7
  } imac_op_e;

  typedef struct packed {
    logic is_signed;  // operands are two's complement
    logic wide;       // 32x32 widening form
    logic sub;        // subtract product from addend
    logic high;       // return upper product half
    logic narrow;     // 32-bit mode of a full-width form
  } imac_ctl_t;

  function automatic imac_ctl_t imac_decode(input logic [3:0] code, input logic m32);
    imac_ctl_t c;
    c = '0;
    case (code)
      OP_MSB:   begin c.sub = 1'b1; c.narrow = m32; end
      OP_SWMAC: begin c.is_signed = 1'b1; c.wide = 1'b1; end
      OP_UWMAC: begin c.wide = 1'b1; end
      OP_SWMSB: begin c.is_signed = 1'b1; c.wide = 1'b1; c.sub = 1'b1; end
      OP_UWMSB: begin c.wide = 1'b1; c.sub = 1'b1; end
      OP_SHI:   begin c.is_signed = 1'b1; c.high = 1'b1; end
      OP_UHI:   begin c.high = 1'b1; end
      default:  begin c.narrow = m32; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/imac_prep.sv
module imac_prep
  import imac_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  imac_ctl_t         ctl,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   mag_a,
  output logic [XLEN-1:0]   mag_b,
  output logic              neg
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] ea, eb;
  logic            sa, sb;

  always_comb begin
    if (ctl.wide) begin
      ea = ctl.is_signed ? {{HLEN{a[HLEN-1]}}, a[HLEN-1:0]} : {{HLEN{1'b0}}, a[HLEN-1:0]};
      eb = ctl.is_signed ? {{HLEN{b[HLEN-1]}}, b[HLEN-1:0]} : {{HLEN{1'b0}}, b[HLEN-1:0]};
    end else if (ctl.narrow) begin
      ea = {{HLEN{1'b0}}, a[HLEN-1:0]};
      eb = {{HLEN{1'b0}}, b[HLEN-1:0]};
    end else begin
      ea = a;
      eb = b;
    end
    sa    = ctl.is_signed & ea[XLEN-1];
    sb    = ctl.is_signed & eb[XLEN-1];
    mag_a = sa ? (~ea + 1'b1) : ea;
    mag_b = sb ? (~eb + 1'b1) : eb;
    neg   = sa ^ sb;
  end

endmodule

// File: rtl/imac_engine.sv
module imac_engine #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  output logic              run,
  output logic              last,
  output logic [2*XLEN-1:0] prod_nx
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   mcand, acc;
  logic [XLEN-1:0] mplier;

  // One multiplier bit per step; the final step is the one after which no
  // set bits remain, so the loop length follows the multiplier magnitude.
  assign prod_nx = mplier[0] ? (acc + mcand) : acc;
  assign last    = run && (mplier[XLEN-1:1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
    end else if (load) begin
      run    <= 1'b1;
      mcand  <= {{XLEN{1'b0}}, mag_a};
      mplier <= mag_b;
      acc    <= '0;
    end else if (run) begin
      acc    <= prod_nx;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      if (last) run <= 1'b0;
    end
  end

endmodule

// File: rtl/imac_finish.sv
module imac_finish
  import imac_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  imac_ctl_t          ctl,
  input  logic               neg,
  input  logic [2*XLEN-1:0]  raw,
  input  logic [XLEN-1:0]    addend,
  output logic [XLEN-1:0]    res
);
  localparam int HLEN = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  logic [PW-1:0]   p;
  logic [HLEN-1:0] s32;

  always_comb begin
    p   = neg ? (~raw + 1'b1) : raw;
    s32 = ctl.sub ? (addend[HLEN-1:0] - p[HLEN-1:0]) : (addend[HLEN-1:0] + p[HLEN-1:0]);
    if (ctl.high)
      res = p[PW-1:XLEN];
    else if (ctl.narrow)
      res = {{HLEN{1'b0}}, s32};
    else
      res = ctl.sub ? (addend - p[XLEN-1:0]) : (addend + p[XLEN-1:0]);
  end

endmodule

// File: rtl/imac_unit.sv
module imac_unit
  import imac_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic            mode32,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] addend,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int PW = 2 * XLEN;

  imac_ctl_t       in_ctl, ctl_q;
  logic [XLEN-1:0] mag_a, mag_b, addend_q, fin_res;
  logic            in_neg, neg_q, load, run, last;
  logic [PW-1:0]   prod_nx;

  assign in_ctl = imac_decode(op, mode32);
  assign load   = start && !run;
  assign busy   = run;

  imac_prep #(.XLEN(XLEN)) u_prep (
    .ctl(in_ctl), .a(opa), .b(opb), .mag_a(mag_a), .mag_b(mag_b), .neg(in_neg)
  );

  imac_engine #(.XLEN(XLEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(load), .mag_a(mag_a), .mag_b(mag_b),
    .run(run), .last(last), .prod_nx(prod_nx)
  );

  imac_finish #(.XLEN(XLEN)) u_fin (
    .ctl(ctl_q), .neg(neg_q), .raw(prod_nx), .addend(addend_q), .res(fin_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      neg_q    <= 1'b0;
      addend_q <= '0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        ctl_q    <= in_ctl;
        neg_q    <= in_neg;
        addend_q <= addend;
      end
      if (last) begin
        done   <= 1'b1;
        result <= fin_res;
      end
    end
  end

endmodule

// File: rtl/imac_unit_chk.sv
module imac_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R10
  no_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);

endmodule

bind imac_unit imac_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_imac_unit.sv
`timescale 1ns/1ps
module sim_imac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        mode32 = 1'b0;
  logic [63:0] opa = '0, opb = '0, addend = '0;
  logic        busy, done;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  imac_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode32(mode32),
    .opa(opa), .opb(opb), .addend(addend),
    .busy(busy), .done(done), .result(result)
  );

  // ---- behavioural reference ----
  function automatic logic [63:0] ref_calc(input logic [3:0] c, input logic m,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    logic [127:0] xa, xb, p;
    logic [31:0]  s;
    case (c)
      4'd1, 4'd0, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: begin
        if (m) begin
          p = {96'd0, a[31:0]} * {96'd0, b[31:0]};
          s = (c == 4'd1) ? d[31:0] - p[31:0] : d[31:0] + p[31:0];
          return {32'd0, s};
        end
        p = {64'd0, a} * {64'd0, b};
        return (c == 4'd1) ? d - p[63:0] : d + p[63:0];
      end
      4'd2, 4'd4: begin  // R4
        xa = {{96{a[31]}}, a[31:0]};
        xb = {{96{b[31]}}, b[31:0]};
        p  = xa * xb;
        return (c == 4'd4) ? d - p[63:0] : d + p[63:0];
      end
      4'd3, 4'd5: begin  // R5
        p = {96'd0, a[31:0]} * {96'd0, b[31:0]};
        return (c == 4'd5) ? d - p[63:0] : d + p[63:0];
      end
      4'd6: begin  // R6
        xa = {{64{a[63]}}, a};
        xb = {{64{b[63]}}, b};
        p  = xa * xb;
        return p[127:64];
      end
      default: begin  // R7
        p = {64'd0, a} * {64'd0, b};
        return p[127:64];
      end
    endcase
  endfunction

  function automatic int ref_lat(input logic [3:0] c, input logic m, input logic [63:0] b);
    logic [63:0] e;
    int n;
    if (c == 4'd2 || c == 4'd4)      e = {{32{b[31]}}, b[31:0]};
    else if (c == 4'd3 || c == 4'd5) e = {32'd0, b[31:0]};
    else if (c == 4'd6 || c == 4'd7) e = b;
    else if (m)                      e = {32'd0, b[31:0]};
    else                             e = b;
    if ((c == 4'd2 || c == 4'd4 || c == 4'd6) && e[63]) e = -e;
    n = 0;
    for (int i = 0; i < 64; i++) if (e[i]) n = i + 1;
    return (n == 0) ? 1 : n;
  endfunction

  logic        m_busy, m_done;
  logic [63:0] m_res, m_pend;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_res <= '0; m_pend <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend;
        end
        m_cnt <= m_cnt - 1;
      end else if (start) begin
        m_busy <= 1'b1;
        m_cnt  <= ref_lat(op, mode32, opb);
        m_pend <= ref_calc(op, mode32, opa, opb, addend);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, half a cycle after the updating edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", "busy", {63'd0, busy}, {63'd0, m_busy});
      chk("R9", "done", {63'd0, done}, {63'd0, m_done});
      chk(m_done ? cur_req : "R11", "result", result, m_res);
    end
  end

  task automatic issue(input logic [3:0] c, input logic m, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] d);
    @(negedge clk);
    op = c; mode32 = m; opa = a; opb = b; addend = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // issue, wait for completion, then check the value once more explicitly
  task automatic run_op(input string req, input logic [3:0] c, input logic m,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    logic [63:0] exp;
    exp = ref_calc(c, m, a, b, d);
    cur_req = req;
    issue(c, m, a, b, d);
    while (!done) @(negedge clk);
    chk(req, "final", result, exp);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200) @(posedge clk);
    while (1) @(posedge clk);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy rst", {63'd0, busy}, 64'd0);
    chk("R1", "done rst", {63'd0, done}, 64'd0);
    chk("R1", "result rst", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "result after rst", result, 64'd0);

    // R2: full-width multiply-add
    run_op("R2", 4'd0, 1'b0, 64'd3, 64'd5, 64'd10);
    run_op("R2", 4'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0);
    run_op("R2", 4'd9, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h55);
    // R3: multiply-subtract, negated multiply
    run_op("R3", 4'd1, 1'b0, 64'd7, 64'd6, 64'd100);
    run_op("R3", 4'd1, 1'b0, 64'd5, 64'd3, 64'd0);
    // R4: signed widening
    run_op("R4", 4'd2, 1'b0, 64'hDEAD_0000_FFFF_FFFF, 64'hBEEF_0000_0000_0002, 64'd10);
    run_op("R4", 4'd4, 1'b0, 64'h0000_0000_FFFF_FFFD, 64'd4, 64'd0);
    run_op("R4", 4'd2, 1'b0, 64'h8000_0000, 64'h8000_0000, 64'd1);
    // R5: unsigned widening
    run_op("R5", 4'd3, 1'b0, 64'hDEAD_0000_FFFF_FFFF, 64'd2, 64'd0);
    run_op("R5", 4'd5, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd0);
    // R6 / R7: high halves, same bit patterns
    run_op("R6", 4'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h99);
    run_op("R7", 4'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h99);
    run_op("R6", 4'd6, 1'b0, 64'h4000_0000_0000_0000, 64'd8, 64'd0);
    run_op("R6", 4'd6, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0);
    run_op("R7", 4'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    // R8: 32-bit mode
    run_op("R8", 4'd0, 1'b1, 64'hAAAA_0000_FFFF_FFFF, 64'h7777_0000_0000_0002, 64'h5555_0000_0000_0001);
    run_op("R8", 4'd1, 1'b1, 64'hAAAA_0000_0000_0003, 64'd3, 64'hFFFF_0000_0000_0004);
    run_op("R8", 4'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0);
    // R9: latency extremes
    run_op("R9", 4'd0, 1'b0, 64'd77, 64'd0, 64'd9);
    run_op("R9", 4'd0, 1'b0, 64'd77, 64'd1, 64'd0);
    run_op("R9", 4'd6, 1'b0, 64'd77, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run_op("R9", 4'd0, 1'b0, 64'd3, 64'h8000_0000_0000_0000, 64'd0);
    // R10: start while busy is ignored
    cur_req = "R10";
    issue(4'd0, 1'b0, 64'd11, 64'h0100_0000_0000_0000, 64'd1);
    repeat (3) @(negedge clk);
    issue(4'd7, 1'b0, 64'hFFFF, 64'd1, 64'd0);
    while (!done) @(negedge clk);
    chk("R10", "ignored start", result, 64'd11 * 64'h0100_0000_0000_0000 + 64'd1);
    // R10: back-to-back, new start in the done cycle
    issue(4'd0, 1'b0, 64'd2, 64'd3, 64'd0);
    while (!done) @(negedge clk);
    cur_req = "R11";
    op = 4'd1; opa = 64'd4; opb = 64'd5; addend = 64'd100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11", "back-to-back", result, 64'd80);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule